// File: doc/BRIEF.md
# Audio Frame Sequencer

This block paces the slow modulators of a sound generator. From the CPU clock it derives a steady step tick. On that tick it sends out a quarter-frame strobe, which clocks the envelope and linear-counter units. On some steps it also sends a half-frame strobe, which clocks the length-counter and sweep units. At the end of a sequence it can raise a frame interrupt. Two sequences are available. The 4-step sequence strobes on every step and can raise the interrupt. The 5-step sequence has a silent fifth step and never interrupts. Because the step rate is the same in both modes, the full cycle takes 4 or 5 step intervals.

Software controls the block through a single write port. Bit 7 of the written byte selects the sequence and bit 6 blocks the interrupt. A write clocks the controlled units at once. It then restarts the sequence from step 1 after a short delay, and the length of that delay depends on the phase of the CPU cycle. The status-register logic clears the interrupt through an acknowledge pulse.

Top module: `frame_sequencer`

## Requirements
- R1: After reset, all three outputs are low. The block is in 4-step mode with the interrupt enabled, and step 1 comes STEP_CLKS cycles after the last reset cycle.
- R2: In 4-step mode (bit 7 = 0), every step gives a quarter-frame strobe, and steps 2 and 4 also give a half-frame strobe. Every half-frame strobe comes together with a quarter-frame strobe.
- R3: In 4-step mode, step 4 sets the frame interrupt flag in the same cycle as its strobes, unless the inhibit bit (bit 6) is set.
- R4: In 5-step mode (bit 7 = 1), steps 1 to 4 give quarter-frame strobes and steps 1 and 3 also give half-frame strobes. Step 5 gives nothing, and this mode never sets the interrupt flag.
- R5: Steps are exactly STEP_CLKS CPU cycles apart, and the sequence wraps after step 4 or step 5, depending on the mode.
- R6: A write on an odd-numbered clock after reset (the first clock is 1) restarts the sequence 3 clocks later. A write on an even-numbered clock restarts it 2 clocks later. Step 1 then follows STEP_CLKS clocks after the restart.
- R7: In the cycle after a write, a quarter-frame strobe is output. A half-frame strobe is also output if bit 7 of the written byte is 1. Bits 5 to 0 of the byte are ignored.
- R8: A write with bit 6 set clears a pending interrupt flag in the cycle after the write, and blocks later flags.
- R9: The interrupt flag stays set until an acknowledge pulse arrives. The acknowledge clears it in the next cycle.
- R10: If an acknowledge arrives in the same cycle as a step-4 flag set, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control-register write strobe |
| ctl_wdata | input | 8 | Control byte: bit 7 is the mode, bit 6 is the interrupt inhibit |
| irq_ack | input | 1 | Interrupt acknowledge from the status logic |
| qtr_frame | output | 1 | Quarter-frame strobe, one cycle wide |
| half_frame | output | 1 | Half-frame strobe, one cycle wide |
| frame_irq | output | 1 | Frame interrupt flag |

## Verification
The step-4 interrupt set and the acknowledge from the status logic can land on the same clock edge. The bench drives `irq_ack` for exactly the cycle in which step 4 of a 4-step cycle fires. It then expects `frame_irq` to read high at that step and to stay high a few cycles later, until a separate acknowledge clears it. Restart phases on both odd and even clocks are also exercised. The bench judges them by the exact cycle of the first step after each write.

// File: rtl/afs_pkg.sv
package afs_pkg;
  typedef enum logic {SEQ_FOUR = 1'b0, SEQ_FIVE = 1'b1} seq_mode_e;
  localparam int MODE_BIT    = 7;
  localparam int INHIBIT_BIT = 6;
  localparam int STEP_W      = 3;
  typedef struct packed {
    logic qtr;
    logic half;
    logic irq;
  } step_evt_t;
endpackage

// File: rtl/afs_step_timer.sv
module afs_step_timer #(
  parameter int STEP_CLKS = 7457
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (STEP_CLKS > 2) ? $clog2(STEP_CLKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick = (cnt_q == LAST) && !restart;

  always_ff @(posedge clk) begin
    if (rst || restart || tick) cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // independent gap counter used only by the spacing check
  int gap_q;
  always_ff @(posedge clk) begin
    if (rst || restart || tick) gap_q <= 0;
    else                        gap_q <= gap_q + 1;
  end

  assert_step_spacing_R5: assert property (@(posedge clk) disable iff (rst)
    tick |-> (gap_q == STEP_CLKS - 1));
  assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/afs_restart_ctl.sv
module afs_restart_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  output logic restart
);
  logic       phase_q;   // 0 when the coming edge is odd-numbered
  logic [1:0] dly_q;

  assign restart = (dly_q == 2'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= 1'b0;
      dly_q   <= 2'd0;
    end else begin
      phase_q <= ~phase_q;
      if (wr_en)              dly_q <= phase_q ? 2'd2 : 2'd3;
      else if (dly_q != 2'd0) dly_q <= dly_q - 2'd1;
    end
  end

  assert_restart_origin_R6: assert property (@(posedge clk) disable iff (rst)
    restart |-> (($past(wr_en, 2) && $past(phase_q, 2)) ||
                 ($past(wr_en, 3) && !$past(phase_q, 3))));
endmodule

// File: rtl/afs_step_decoder.sv
module afs_step_decoder
  import afs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      restart,
  input  seq_mode_e mode,
  output step_evt_t evt
);
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] last_idx;
  step_evt_t         pat;

  assign last_idx = (mode == SEQ_FIVE) ? STEP_W'(4) : STEP_W'(3);

  always_comb begin
    pat = '0;
    if (mode == SEQ_FOUR) begin
      pat.qtr  = 1'b1;
      pat.half = step_q[0];
      pat.irq  = (step_q == STEP_W'(3));
    end else begin
      pat.qtr  = (step_q != STEP_W'(4));
      pat.half = (step_q == STEP_W'(0)) || (step_q == STEP_W'(2));
      pat.irq  = 1'b0;
    end
    evt = tick ? pat : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || restart)            step_q <= '0;
    else if (tick) begin
      if (step_q >= last_idx)      step_q <= '0;
      else                         step_q <= step_q + 1'b1;
    end
  end

  assert_no_irq_five_R4: assert property (@(posedge clk) disable iff (rst)
    (mode == SEQ_FIVE) |-> !evt.irq);
  assert_irq_on_tick_R3: assert property (@(posedge clk) disable iff (rst)
    evt.irq |-> (tick && evt.half && evt.qtr));
endmodule

// File: rtl/afs_irq_flag.sv
module afs_irq_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr_wr,
  input  logic ack,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)         flag <= 1'b0;
    else if (clr_wr) flag <= 1'b0;
    else if (set)    flag <= 1'b1;
    else if (ack)    flag <= 1'b0;
  end

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (flag && !ack && !clr_wr) |=> flag);
  assert_set_beats_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (set && !clr_wr) |=> flag);
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
  import afs_pkg::*;
#(
  parameter int STEP_CLKS = 7457
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       irq_ack,
  output logic       qtr_frame,
  output logic       half_frame,
  output logic       frame_irq
);
  seq_mode_e mode_q;
  logic      inhibit_q;
  logic      restart;
  logic      tick;
  step_evt_t evt;
  logic      unused_bits;

  assign unused_bits = ^ctl_wdata[5:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= SEQ_FOUR;
      inhibit_q <= 1'b0;
    end else if (ctl_we) begin
      mode_q    <= seq_mode_e'(ctl_wdata[MODE_BIT]);
      inhibit_q <= ctl_wdata[INHIBIT_BIT];
    end
  end

  afs_restart_ctl u_restart (
    .clk(clk), .rst(rst), .wr_en(ctl_we), .restart(restart)
  );

  afs_step_timer #(.STEP_CLKS(STEP_CLKS)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick)
  );

  afs_step_decoder u_dec (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .mode(mode_q), .evt(evt)
  );

  afs_irq_flag u_irq (
    .clk(clk), .rst(rst),
    .set(evt.irq && !inhibit_q),
    .clr_wr(ctl_we && ctl_wdata[INHIBIT_BIT]),
    .ack(irq_ack),
    .flag(frame_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      qtr_frame  <= 1'b0;
      half_frame <= 1'b0;
    end else begin
      qtr_frame  <= evt.qtr  | ctl_we;
      half_frame <= evt.half | (ctl_we & ctl_wdata[MODE_BIT]);
    end
  end

  assert_half_has_qtr_R2: assert property (@(posedge clk) disable iff (rst)
    half_frame |-> qtr_frame);
  assert_write_strobe_R7: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> qtr_frame);
  assert_inhibit_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata[INHIBIT_BIT]) |=> !frame_irq);
endmodule

// File: tb/tb_frame_sequencer.sv
module tb_frame_sequencer;
  localparam int S = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_we = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       irq_ack = 1'b0;
  logic       qtr_frame, half_frame, frame_irq;

  frame_sequencer #(.STEP_CLKS(S)) dut (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_ack(irq_ack), .qtr_frame(qtr_frame), .half_frame(half_frame),
    .frame_irq(frame_irq)
  );

  always #2 clk = ~clk;

  typedef struct {
    int    cyc;
    bit    q;
    bit    h;
    string req;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0;
  int   checks = 0;
  int   fails = 0;
  bit   run = 1'b0;
  bit   done = 1'b0;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic chk(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, expv);
    end
  endtask

  task automatic push(int c, bit q, bit h, string req);
    exp_t e;
    e.cyc = c; e.q = q; e.h = h; e.req = req;
    exp_q.push_back(e);
  endtask

  // expected strobes of n steps after a restart at edge r
  task automatic push_steps(int r, bit five, int n);
    for (int i = 0; i < n; i++) begin
      int  idx = five ? (i % 5) : (i % 4);
      bit  q, h;
      string tag;
      if (five) begin
        q = (idx != 4);
        h = (idx == 0) || (idx == 2);
      end else begin
        q = 1'b1;
        h = idx[0];
      end
      tag = (i == 0) ? "R6" : (five ? "R4" : "R2");
      if (q || h) push(r + (i + 1) * S, q, h, tag);
    end
  endtask

  task automatic wait_cyc(int n);
    forever begin
      @(negedge clk);
      if (cyc == n) break;
    end
  endtask

  // write sampled at edge k; expects strobes and the restarted sequence
  task automatic drv_write(int k, logic [7:0] d, int nsteps);
    int dly;
    dly = (k % 2 == 1) ? 3 : 2;
    wait_cyc(k - 1);
    ctl_we = 1'b1;
    ctl_wdata = d;
    push(k, 1'b1, d[7], "R7");
    push_steps(k + dly, d[7], nsteps);
    wait_cyc(k);
    ctl_we = 1'b0;
    ctl_wdata = 8'h00;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && run) begin
      while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
        checks++; fails++;
        $display("FAIL %s missing strobe: actual none expected q=%0d h=%0d at cycle %0d",
                 exp_q[0].req, exp_q[0].q, exp_q[0].h, exp_q[0].cyc);
        void'(exp_q.pop_front());
      end
      if (qtr_frame || half_frame) begin
        checks++;
        if (exp_q.size() == 0 || exp_q[0].cyc != cyc) begin
          fails++;
          $display("FAIL R5 unexpected strobe at cycle %0d: actual q=%0d h=%0d expected none",
                   cyc, qtr_frame, half_frame);
        end else begin
          if (exp_q[0].q != qtr_frame || exp_q[0].h != half_frame) begin
            fails++;
            $display("FAIL %s strobe at cycle %0d: actual q=%0d h=%0d expected q=%0d h=%0d",
                     exp_q[0].req, cyc, qtr_frame, half_frame, exp_q[0].q, exp_q[0].h);
          end
          void'(exp_q.pop_front());
        end
      end
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", qtr_frame, 0, "qtr after reset");
    chk("R1", half_frame, 0, "half after reset");
    chk("R1", frame_irq, 0, "irq after reset");
    push(S, 1, 0, "R1");
    push(2 * S, 1, 1, "R2");
    push(3 * S, 1, 0, "R5");
    push(4 * S, 1, 1, "R2");
    run = 1'b1;

    wait_cyc(4 * S - 1);
    chk("R3", frame_irq, 0, "irq before step 4");
    wait_cyc(4 * S);
    chk("R3", frame_irq, 1, "irq at step 4");
    wait_cyc(4 * S + 5);
    chk("R9", frame_irq, 1, "irq held without ack");
    wait_cyc(86);
    irq_ack = 1'b1;
    wait_cyc(87);
    irq_ack = 1'b0;
    chk("R9", frame_irq, 0, "irq after ack");

    // 5-step mode, odd write clock: restart 3 later
    drv_write(91, 8'h80, 6);
    wait_cyc(200);
    chk("R4", frame_irq, 0, "no irq in 5-step mode");

    // 4-step mode, even write clock: restart 2 later
    drv_write(220, 8'h00, 8);
    wait_cyc(301);
    irq_ack = 1'b1;
    wait_cyc(302);
    irq_ack = 1'b0;
    chk("R10", frame_irq, 1, "set and ack same cycle");
    wait_cyc(305);
    chk("R10", frame_irq, 1, "irq still held");
    wait_cyc(309);
    irq_ack = 1'b1;
    wait_cyc(310);
    irq_ack = 1'b0;
    chk("R9", frame_irq, 0, "irq cleared by ack");
    wait_cyc(385);
    chk("R3", frame_irq, 1, "irq at second step 4");

    // inhibit write with ignored low bits set
    drv_write(390, 8'h5F, 4);
    chk("R8", frame_irq, 0, "irq cleared by inhibit write");
    wait_cyc(475);
    chk("R8", frame_irq, 0, "irq blocked by inhibit");
    wait_cyc(480);
    chk("R5", exp_q.size(), 0, "pending expected strobes");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule